// File: doc/BRIEF.md
# Translation Request Permission Checker

This block sits on the host side of an I/O path. It answers address translation requests sent by device functions. A request names the function by its 16-bit routing ID (8-bit bus, 5-bit device, 3-bit function). It also carries an untranslated virtual page number and the access the function wants, read and/or write. Every request goes through three checks in a fixed order:

1. Is the function enabled to use the translation service?
2. Does it hold the rights it asks for?
3. Is a translation present?

Exactly one completion comes back for each request. It carries the routing ID of the requester and a 2-bit status. On success it also returns the physical page and the permissions granted.

Two small tables are written through a simple register port:

- A 16-bit enable table, indexed by a function slot.
- A 16-entry protection table, keyed by routing ID and virtual page.

Requests are served one at a time and in order. Each one has a fixed two-cycle latency.

Top module: `xlat_perm_chk`

## Requirements
- R1: `req_ready_o` is 1 when idle. It is 0 from the cycle after a request is accepted until the cycle after its completion handshake (`cpl_valid_o` and `cpl_ready_i` both 1). No second request is accepted while one is outstanding.
- R2: A request accepted at clock edge k raises `cpl_valid_o` at edge k+2. `cpl_valid_o` stays 0 in the cycle between those edges.
- R3: While `cpl_valid_o` is 1 and `cpl_ready_i` is 0, `cpl_valid_o` and every completion field hold their values.
- R4: `cpl_rid_o` equals the routing ID of the request being completed.
- R5: The function slot is the low 4 bits of the routing ID, that is device bit 0 followed by the 3 function bits. If the enable bit for that slot is 0, the status is 01, whatever the protection table holds.
- R6: A protection entry matches only when all three hold: its valid bit is 1, its stored routing ID equals the full 16-bit request routing ID, and its page number equals the request page. When several entries match, the lowest index is used.
- R7: For an enabled function with a matching entry, the status is 10 when read is requested and the entry lacks read permission. It is also 10 when write is requested and the entry lacks write permission.
- R8: For an enabled function with no matching entry, the status is 11.
- R9: Status 00 returns the entry's physical page and its read and write bits. Any non-zero status returns page 0 and both permission bits 0.
- R10: A table write on edge w affects every request accepted at an edge after w. This holds for setting or clearing an enable bit and for writing or invalidating a protection entry.
- R11: After reset all enable bits are 0, all protection entries are invalid, `cpl_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_rid_i | input | 16 | Requester routing ID (bus, device, function) |
| req_vpn_i | input | VPN_W | Untranslated page number |
| req_rd_i | input | 1 | Read access requested |
| req_wr_i | input | 1 | Write access requested |
| cpl_valid_o | output | 1 | Completion valid |
| cpl_ready_i | input | 1 | Completion ready |
| cpl_rid_o | output | 16 | Routing ID of the function being answered |
| cpl_status_o | output | 2 | 00 ok, 01 not enabled, 10 denied, 11 no translation |
| cpl_ppn_o | output | PPN_W | Physical page on success, else 0 |
| cpl_rd_o | output | 1 | Read granted |
| cpl_wr_o | output | 1 | Write granted |
| en_we_i | input | 1 | Enable table write strobe |
| en_slot_i | input | log2(N_SLOT) | Enable table slot |
| en_set_i | input | 1 | Enable bit value to write |
| pt_we_i | input | 1 | Protection table write strobe |
| pt_idx_i | input | log2(N_ENT) | Protection entry index |
| pt_valid_i | input | 1 | Entry valid bit |
| pt_rid_i | input | 16 | Entry routing ID |
| pt_vpn_i | input | VPN_W | Entry virtual page |
| pt_ppn_i | input | PPN_W | Entry physical page |
| pt_rd_i | input | 1 | Entry read permission |
| pt_wr_i | input | 1 | Entry write permission |

## Verification
The assertions check the handshake contract on every cycle:

- one outstanding request at a time;
- the exact two-edge latency;
- completion fields held under back-pressure;
- the returned routing ID matching the accepted request;
- zeroed page and permissions on every failure;
- requested rights being covered on every success.

Only the bench scenarios can show the rest:

- which status a given table content yields;
- that the enable check wins over a matching entry;
- that the full routing ID, not only the slot, forms the key;
- the lowest-index choice among duplicate entries;
- that table updates reach later requests.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int RID_W = 16;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
  } rid_t;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_NOT_EN  = 2'b01,
    ST_DENIED  = 2'b10,
    ST_NO_XLAT = 2'b11
  } cpl_st_e;
endpackage

// File: rtl/xlat_en_tbl.sv
module xlat_en_tbl #(
  parameter int N_SLOT = 16,
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic              wr_set_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic              en_o
);
  logic [N_SLOT-1:0] en_q;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[s] <= 1'b0;
      else if (we_i && wr_slot_i == SLOT_W'(s)) en_q[s] <= wr_set_i;
    end
  end

  assign en_o = en_q[rd_slot_i];
endmodule

// File: rtl/xlat_prot_tbl.sv
module xlat_prot_tbl #(
  parameter int N_ENT = 16,
  parameter int RID_W = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [RID_W-1:0] wr_rid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             wr_rd_i,
  input  logic             wr_wr_i,
  input  logic [RID_W-1:0] lk_rid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic             hit_rd_o,
  output logic             hit_wr_o
);
  logic [N_ENT-1:0] vld_q, prd_q, pwr_q, match;
  logic [RID_W-1:0] rid_q [N_ENT];
  logic [VPN_W-1:0] vpn_q [N_ENT];
  logic [PPN_W-1:0] ppn_q [N_ENT];
  logic [IDX_W-1:0] sel;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
        prd_q[e] <= 1'b0;
        pwr_q[e] <= 1'b0;
        rid_q[e] <= '0;
        vpn_q[e] <= '0;
        ppn_q[e] <= '0;
      end else if (we_i && wr_idx_i == IDX_W'(e)) begin
        vld_q[e] <= wr_valid_i;
        prd_q[e] <= wr_rd_i;
        pwr_q[e] <= wr_wr_i;
        rid_q[e] <= wr_rid_i;
        vpn_q[e] <= wr_vpn_i;
        ppn_q[e] <= wr_ppn_i;
      end
    end
    assign match[e] = vld_q[e] && (rid_q[e] == lk_rid_i) && (vpn_q[e] == lk_vpn_i);
  end

  // lowest matching index wins
  always_comb begin
    hit_o = 1'b0;
    sel   = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit_o = 1'b1;
        sel   = IDX_W'(e);
      end
    end
  end

  assign hit_ppn_o = ppn_q[sel];
  assign hit_rd_o  = prd_q[sel];
  assign hit_wr_o  = pwr_q[sel];
endmodule

// File: rtl/xlat_perm_chk.sv
module xlat_perm_chk
  import xlat_pkg::*;
#(
  parameter int N_SLOT = 16,
  parameter int N_ENT  = 16,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 24,
  localparam int SLOT_W = $clog2(N_SLOT),
  localparam int IDX_W  = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [RID_W-1:0]  req_rid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic              req_rd_i,
  input  logic              req_wr_i,
  output logic              cpl_valid_o,
  input  logic              cpl_ready_i,
  output logic [RID_W-1:0]  cpl_rid_o,
  output logic [1:0]        cpl_status_o,
  output logic [PPN_W-1:0]  cpl_ppn_o,
  output logic              cpl_rd_o,
  output logic              cpl_wr_o,
  input  logic              en_we_i,
  input  logic [SLOT_W-1:0] en_slot_i,
  input  logic              en_set_i,
  input  logic              pt_we_i,
  input  logic [IDX_W-1:0]  pt_idx_i,
  input  logic              pt_valid_i,
  input  logic [RID_W-1:0]  pt_rid_i,
  input  logic [VPN_W-1:0]  pt_vpn_i,
  input  logic [PPN_W-1:0]  pt_ppn_i,
  input  logic              pt_rd_i,
  input  logic              pt_wr_i
);
  logic             s1_valid_q, s1_rd_q, s1_wr_q;
  logic [RID_W-1:0] s1_rid_q;
  logic [VPN_W-1:0] s1_vpn_q;
  logic             accept, slot_en, hit, hit_rd, hit_wr, short_perm;
  logic [PPN_W-1:0] hit_ppn;
  cpl_st_e          st_d, st_q;
  logic             cpl_valid_q, cpl_rd_q, cpl_wr_q;
  logic [RID_W-1:0] cpl_rid_q;
  logic [PPN_W-1:0] cpl_ppn_q;

  assign req_ready_o = !s1_valid_q && !cpl_valid_q;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_rid_q   <= '0;
      s1_vpn_q   <= '0;
      s1_rd_q    <= 1'b0;
      s1_wr_q    <= 1'b0;
    end else begin
      s1_valid_q <= accept;
      if (accept) begin
        s1_rid_q <= req_rid_i;
        s1_vpn_q <= req_vpn_i;
        s1_rd_q  <= req_rd_i;
        s1_wr_q  <= req_wr_i;
      end
    end
  end

  xlat_en_tbl #(.N_SLOT(N_SLOT)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (en_we_i),
    .wr_slot_i (en_slot_i),
    .wr_set_i  (en_set_i),
    .rd_slot_i (s1_rid_q[SLOT_W-1:0]),
    .en_o      (slot_en)
  );

  xlat_prot_tbl #(
    .N_ENT (N_ENT),
    .RID_W (RID_W),
    .VPN_W (VPN_W),
    .PPN_W (PPN_W)
  ) u_pt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (pt_we_i),
    .wr_idx_i   (pt_idx_i),
    .wr_valid_i (pt_valid_i),
    .wr_rid_i   (pt_rid_i),
    .wr_vpn_i   (pt_vpn_i),
    .wr_ppn_i   (pt_ppn_i),
    .wr_rd_i    (pt_rd_i),
    .wr_wr_i    (pt_wr_i),
    .lk_rid_i   (s1_rid_q),
    .lk_vpn_i   (s1_vpn_q),
    .hit_o      (hit),
    .hit_ppn_o  (hit_ppn),
    .hit_rd_o   (hit_rd),
    .hit_wr_o   (hit_wr)
  );

  assign short_perm = (s1_rd_q && !hit_rd) || (s1_wr_q && !hit_wr);

  // ordered checks: enable, rights, presence
  always_comb begin
    if (!slot_en)                st_d = ST_NOT_EN;
    else if (hit && short_perm)  st_d = ST_DENIED;
    else if (!hit)               st_d = ST_NO_XLAT;
    else                         st_d = ST_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_valid_q <= 1'b0;
      cpl_rid_q   <= '0;
      st_q        <= ST_OK;
      cpl_ppn_q   <= '0;
      cpl_rd_q    <= 1'b0;
      cpl_wr_q    <= 1'b0;
    end else if (s1_valid_q) begin
      cpl_valid_q <= 1'b1;
      cpl_rid_q   <= s1_rid_q;
      st_q        <= st_d;
      cpl_ppn_q   <= (st_d == ST_OK) ? hit_ppn : '0;
      cpl_rd_q    <= (st_d == ST_OK) && hit_rd;
      cpl_wr_q    <= (st_d == ST_OK) && hit_wr;
    end else if (cpl_valid_q && cpl_ready_i) begin
      cpl_valid_q <= 1'b0;
    end
  end

  assign cpl_valid_o  = cpl_valid_q;
  assign cpl_rid_o    = cpl_rid_q;
  assign cpl_status_o = st_q;
  assign cpl_ppn_o    = cpl_ppn_q;
  assign cpl_rd_o     = cpl_rd_q;
  assign cpl_wr_o     = cpl_wr_q;
endmodule

// File: rtl/xlat_perm_chk_sva.sv
module xlat_perm_chk_sva #(
  parameter int RID_W = 16,
  parameter int PPN_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [RID_W-1:0] req_rid_i,
  input logic             req_rd_i,
  input logic             req_wr_i,
  input logic             cpl_valid_o,
  input logic             cpl_ready_i,
  input logic [RID_W-1:0] cpl_rid_o,
  input logic [1:0]       cpl_status_o,
  input logic [PPN_W-1:0] cpl_ppn_o,
  input logic             cpl_rd_o,
  input logic             cpl_wr_o
);
  logic [RID_W-1:0] last_rid_q;
  logic             last_rd_q, last_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_rid_q <= '0;
      last_rd_q  <= 1'b0;
      last_wr_q  <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      last_rid_q <= req_rid_i;
      last_rd_q  <= req_rd_i;
      last_wr_q  <= req_wr_i;
    end
  end

  // R1
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> !req_ready_o);

  // R2
  no_early_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !cpl_valid_o);

  // R2
  cpl_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> ##2 cpl_valid_o);

  // R3
  cpl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && !cpl_ready_i) |=> (cpl_valid_o && $stable(cpl_status_o) &&
      $stable(cpl_ppn_o) && $stable(cpl_rid_o) && $stable(cpl_rd_o) && $stable(cpl_wr_o)));

  // R4
  cpl_rid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> (cpl_rid_o == last_rid_q));

  // R9
  fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && cpl_status_o != 2'b00) |-> (cpl_ppn_o == '0 && !cpl_rd_o && !cpl_wr_o));

  // R7
  grant_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && cpl_status_o == 2'b00) |-> ((cpl_rd_o || !last_rd_q) && (cpl_wr_o || !last_wr_q)));
endmodule

bind xlat_perm_chk xlat_perm_chk_sva #(.RID_W(xlat_pkg::RID_W), .PPN_W(PPN_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_rid_i    (req_rid_i),
  .req_rd_i     (req_rd_i),
  .req_wr_i     (req_wr_i),
  .cpl_valid_o  (cpl_valid_o),
  .cpl_ready_i  (cpl_ready_i),
  .cpl_rid_o    (cpl_rid_o),
  .cpl_status_o (cpl_status_o),
  .cpl_ppn_o    (cpl_ppn_o),
  .cpl_rd_o     (cpl_rd_o),
  .cpl_wr_o     (cpl_wr_o)
);

// File: tb/sim_xlat_perm_chk.sv
`timescale 1ns/1ps
module sim_xlat_perm_chk;
  localparam int VPN_W = 20;
  localparam int PPN_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid = 0, req_rd = 0, req_wr = 0, cpl_ready = 0;
  logic [15:0]      req_rid = '0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic             req_ready, cpl_valid, cpl_rd, cpl_wr;
  logic [15:0]      cpl_rid;
  logic [1:0]       cpl_status;
  logic [PPN_W-1:0] cpl_ppn;
  logic             en_we = 0, en_set = 0;
  logic [3:0]       en_slot = '0;
  logic             pt_we = 0, pt_valid = 0, pt_rd = 0, pt_wr = 0;
  logic [3:0]       pt_idx = '0;
  logic [15:0]      pt_rid = '0;
  logic [VPN_W-1:0] pt_vpn = '0;
  logic [PPN_W-1:0] pt_ppn = '0;

  int n_chk = 0, n_fail = 0;

  xlat_perm_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_rid_i(req_rid),
    .req_vpn_i(req_vpn), .req_rd_i(req_rd), .req_wr_i(req_wr),
    .cpl_valid_o(cpl_valid), .cpl_ready_i(cpl_ready), .cpl_rid_o(cpl_rid),
    .cpl_status_o(cpl_status), .cpl_ppn_o(cpl_ppn), .cpl_rd_o(cpl_rd), .cpl_wr_o(cpl_wr),
    .en_we_i(en_we), .en_slot_i(en_slot), .en_set_i(en_set),
    .pt_we_i(pt_we), .pt_idx_i(pt_idx), .pt_valid_i(pt_valid), .pt_rid_i(pt_rid),
    .pt_vpn_i(pt_vpn), .pt_ppn_i(pt_ppn), .pt_rd_i(pt_rd), .pt_wr_i(pt_wr)
  );

  // bus 0x12 / 0x34, device 3, function 2 -> slot 4'b1010 for both
  localparam logic [15:0] RID_A = {8'h12, 5'd3, 3'd2};
  localparam logic [15:0] RID_B = {8'h34, 5'd3, 3'd2};
  localparam logic [15:0] RID_C = {8'h12, 5'd4, 3'd5};
  localparam logic [3:0]  SLOT_A = 4'b1010;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_en(input logic [3:0] slot, input logic val);
    @(negedge clk); en_we = 1; en_slot = slot; en_set = val;
    @(negedge clk); en_we = 0;
  endtask

  task automatic wr_pt(input logic [3:0] idx, input logic v, input logic [15:0] rid,
                       input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                       input logic r, input logic w);
    @(negedge clk);
    pt_we = 1; pt_idx = idx; pt_valid = v; pt_rid = rid; pt_vpn = vpn;
    pt_ppn = ppn; pt_rd = r; pt_wr = w;
    @(negedge clk); pt_we = 0;
  endtask

  task automatic run_req(input string tag, input logic [15:0] rid, input logic [VPN_W-1:0] vpn,
                         input logic r, input logic w, input logic [1:0] est,
                         input logic [PPN_W-1:0] eppn, input logic erd, input logic ewr,
                         input int hold);
    @(negedge clk);
    req_valid = 1; req_rid = rid; req_vpn = vpn; req_rd = r; req_wr = w;
    @(negedge clk);
    req_valid = 0;
    chk("R2", "cpl_valid one cycle after accept", 32'(cpl_valid), 0);
    chk("R1", "req_ready while pending", 32'(req_ready), 0);
    @(negedge clk);
    chk("R2", "cpl_valid two cycles after accept", 32'(cpl_valid), 1);
    chk(tag, "status", 32'(cpl_status), 32'(est));
    chk(tag, "ppn", 32'(cpl_ppn), 32'(eppn));
    chk(tag, "rd grant", 32'(cpl_rd), 32'(erd));
    chk(tag, "wr grant", 32'(cpl_wr), 32'(ewr));
    chk("R4", "cpl rid", 32'(cpl_rid), 32'(rid));
    for (int i = 0; i < hold; i++) begin
      req_valid = 1; req_rid = RID_C;
      @(negedge clk);
      chk("R3", "cpl_valid held", 32'(cpl_valid), 1);
      chk("R3", "status held", 32'(cpl_status), 32'(est));
      chk("R3", "ppn held", 32'(cpl_ppn), 32'(eppn));
      chk("R1", "no accept while pending", 32'(req_ready), 0);
    end
    req_valid = 0;
    cpl_ready = 1;
    @(negedge clk);
    cpl_ready = 0;
    chk("R1", "cpl_valid after handshake", 32'(cpl_valid), 0);
    chk("R1", "req_ready after handshake", 32'(req_ready), 1);
  endtask

  task automatic t_reset;
    chk("R11", "req_ready after reset", 32'(req_ready), 1);
    chk("R11", "cpl_valid after reset", 32'(cpl_valid), 0);
    // R11: no enable, empty table
    run_req("R11", RID_A, 20'h00100, 1, 0, 2'b01, 0, 0, 0, 0);
  endtask

  task automatic t_enable_first;
    wr_pt(4'd2, 1, RID_A, 20'h00100, 24'hABCDE1, 1, 1);
    // R5: matching entry but slot disabled
    run_req("R5", RID_A, 20'h00100, 1, 0, 2'b01, 0, 0, 0, 0);
    wr_en(SLOT_A, 1);
  endtask

  task automatic t_success;
    // R9: read on rw entry
    run_req("R9", RID_A, 20'h00100, 1, 0, 2'b00, 24'hABCDE1, 1, 1, 0);
    // R9: read+write
    run_req("R9", RID_A, 20'h00100, 1, 1, 2'b00, 24'hABCDE1, 1, 1, 0);
  endtask

  task automatic t_denied;
    wr_pt(4'd5, 1, RID_A, 20'h00200, 24'h000777, 1, 0);
    // R7: write on read-only
    run_req("R7", RID_A, 20'h00200, 0, 1, 2'b10, 0, 0, 0, 0);
    wr_pt(4'd6, 1, RID_A, 20'h00300, 24'h000888, 0, 1);
    // R7: read on write-only
    run_req("R7", RID_A, 20'h00300, 1, 0, 2'b10, 0, 0, 0, 0);
    run_req("R7", RID_A, 20'h00300, 0, 1, 2'b00, 24'h000888, 0, 1, 0);
  endtask

  task automatic t_no_xlat;
    // R8: page with no entry
    run_req("R8", RID_A, 20'h00999, 1, 0, 2'b11, 0, 0, 0, 0);
    // R6: same slot, different bus does not match
    run_req("R6", RID_B, 20'h00100, 1, 0, 2'b11, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    wr_pt(4'd7, 1, RID_A, 20'h00400, 24'h0000B7, 1, 1);
    wr_pt(4'd3, 1, RID_A, 20'h00400, 24'h0000A3, 1, 0);
    // R6: lowest index wins
    run_req("R6", RID_A, 20'h00400, 1, 0, 2'b00, 24'h0000A3, 1, 0, 0);
    run_req("R6", RID_A, 20'h00400, 0, 1, 2'b10, 0, 0, 0, 0);
  endtask

  task automatic t_backpressure;
    // R3: held four cycles
    run_req("R3", RID_A, 20'h00100, 0, 1, 2'b00, 24'hABCDE1, 1, 1, 4);
  endtask

  task automatic t_updates;
    wr_pt(4'd2, 0, RID_A, 20'h00100, 24'hABCDE1, 1, 1);
    // R10: invalidated entry
    run_req("R10", RID_A, 20'h00100, 1, 0, 2'b11, 0, 0, 0, 0);
    wr_en(SLOT_A, 0);
    // R10: slot disabled again
    run_req("R10", RID_A, 20'h00200, 1, 0, 2'b01, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable_first();
    t_success();
    t_denied();
    t_no_xlat();
    t_priority();
    t_backpressure();
    t_updates();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule